// File: doc/BRIEF.md
# Timed EEPROM programming controller

This block is a register-mapped controller for a small byte-wide nonvolatile data store. The store is modelled as an on-chip byte array. A host writes and reads four byte registers through a simple select/strobe bus: a control register, a data register and two address bytes. Through the control register the host can fetch a byte into the data register. It can also start a timed program operation on the addressed cell. That operation is an erase, a write, or an erase followed by a write.

A program start needs a two-step sequence. The host first opens a short arming window, and a program request made while that window is open is honoured. While an operation runs, the controller counts down its duration and refuses further program requests. Reads and program starts each hold the processor for a fixed number of cycles through a stall output. A level-type ready interrupt tells the host when it may start the next operation.

Top module: `eep_ctrl`

## Requirements
- R1: After reset every register reads 0, `cpu_stall` and `irq` are 0, and every array cell holds 0xFF.
- R2: Register select 0 is control, 1 is data, 2 is address bits 7:0 and 3 is address bits 15:8. The array address is {address high, address low} cut to ADDR_W bits. A control write stores bit 3 (interrupt enable) and bits 5:4 (mode). The control register reads back {2'b00, mode, interrupt enable, arm open, busy, 1'b0}, so bit 0 (read strobe) always reads 0.
- R3: Writing control with bit 2 set opens the arming window for the ARM_CYC cycles that follow, and control bit 2 reads 1 during exactly those cycles. A program request (control bit 1) is accepted in one of those cycles, or in the same write that sets bit 2.
- R4: A program request made outside the arming window leaves the array unchanged, does not raise busy and does not stall.
- R5: A program request made while busy is ignored: the array is unchanged and the busy period is not extended.
- R6: At program start the addressed cell becomes 0xFF if mode bit 5 is 0. Then, if mode bit 4 is 0, the cell is AND-ed with the data register. Both actions take effect in the same clock edge.
- R7: Control bit 1 (busy) reads 1 for exactly ERASE_CYC, WRITE_CYC or ERASE_CYC+WRITE_CYC cycles after the start, depending on the actions chosen. With mode 2'b11 nothing changes and busy stays 0.
- R8: A control write with bit 0 set loads the data register from the addressed cell and raises `cpu_stall` for 4 cycles, during which `irq` is held low. In that same write the read takes precedence and any program request is dropped.
- R9: An accepted program request raises `cpu_stall` for 2 cycles.
- R10: `irq` is 1 exactly when the interrupt enable is 1, busy is 0 and no read stall is in progress.
- R11: Data and address register writes take effect while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| cpu_stall | output | 1 | Processor hold request |
| irq | output | 1 | Ready interrupt level |

## Verification
The functions that can collide in one cycle are the read strobe and the program request. Both sit in the same control byte, so a single write of 0x2F sets the read strobe, the program request, the arm bit and the interrupt enable together. The bench expects the read to win: the data register is refreshed, busy stays 0, the stall lasts 4 cycles and `irq` stays low throughout. A second collision pairs arm and program in one write, which must start the operation. A third case places a program request on the last and on the first-expired cycle of the window, and the behavioural model judges every cycle.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [1:0] {
    SEL_CTL  = 2'd0,
    SEL_DATA = 2'd1,
    SEL_ALO  = 2'd2,
    SEL_AHI  = 2'd3
  } reg_sel_t;

  localparam int CB_READ = 0;
  localparam int CB_PROG = 1;
  localparam int CB_ARM  = 2;
  localparam int CB_IEN  = 3;
  localparam int CB_NOWR = 4;  // 1: skip the AND step
  localparam int CB_NOER = 5;  // 1: skip the erase step
endpackage

// File: rtl/eep_countdown.sv
module eep_countdown #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         nz
);
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (load)          cnt_d = load_val;
    else if (cnt != '0) cnt_d = cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  assign nz = (cnt != '0);

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && nz) |=> (cnt == $past(cnt) - 1'b1)); // R7
endmodule

// File: rtl/eep_cell_array.sv
module eep_cell_array #(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              upd_en,
  input  logic              do_erase,
  input  logic              do_write,
  input  logic [7:0]        wbyte,
  output logic [7:0]        rbyte
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];
  logic [7:0] cell_next;

  always_comb begin
    cell_next = mem[addr];
    if (do_erase) cell_next = 8'hFF;
    if (do_write) cell_next = cell_next & wbyte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (upd_en) begin
      mem[addr] <= cell_next;
    end
  end

  assign rbyte = mem[addr];

  AST_WRITE_ONLY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !do_erase) |-> ((cell_next & ~mem[addr]) == 8'h00)); // R6
endmodule

// File: rtl/eep_ctrl.sv
module eep_ctrl #(
  parameter int ADDR_W    = 9,
  parameter int ERASE_CYC = 28800,
  parameter int WRITE_CYC = 28800,
  parameter int ARM_CYC   = 4,
  parameter int RD_STALL  = 4,
  parameter int PG_STALL  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic [1:0] bus_sel,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       cpu_stall,
  output logic       irq
);
  import eep_pkg::*;

  localparam int BW  = $clog2(ERASE_CYC + WRITE_CYC + 1);
  localparam int AW  = $clog2(ARM_CYC + 1);
  localparam int SMX = (RD_STALL > PG_STALL) ? RD_STALL : PG_STALL;
  localparam int SW  = $clog2(SMX + 1);

  // register state
  logic       ien_q, ien_d;
  logic [1:0] mode_q, mode_d;
  logic [7:0] data_q, data_d;
  logic [7:0] alo_q, alo_d;
  logic [7:0] ahi_q, ahi_d;
  logic       rdk_q, rdk_d;

  // decode
  logic              ctl_wr, rd_req, prog_go, do_erase, do_write;
  logic [BW-1:0]     dur, busy_cnt;
  logic [AW-1:0]     arm_cnt;
  logic [SW-1:0]     stall_cnt, stall_val;
  logic              arm_nz, busy_nz, stall_nz;
  logic [ADDR_W-1:0] cell_addr;
  logic [15:0]       full_addr;
  logic [7:0]        cell_rd;

  assign ctl_wr   = bus_wr && (bus_sel == SEL_CTL);
  assign rd_req   = ctl_wr && bus_wdata[CB_READ];
  assign do_erase = !bus_wdata[CB_NOER];
  assign do_write = !bus_wdata[CB_NOWR];
  assign prog_go  = ctl_wr && !bus_wdata[CB_READ] && bus_wdata[CB_PROG]
                    && (arm_nz || bus_wdata[CB_ARM]) && !busy_nz;
  assign dur      = (do_erase ? BW'(ERASE_CYC) : '0) + (do_write ? BW'(WRITE_CYC) : '0);
  assign stall_val = rd_req ? SW'(RD_STALL) : SW'(PG_STALL);
  assign full_addr = {ahi_q, alo_q};
  assign cell_addr = full_addr[ADDR_W-1:0];

  eep_countdown #(.W(AW)) u_arm (
    .clk(clk), .rst_n(rst_n), .load(ctl_wr && bus_wdata[CB_ARM]),
    .load_val(AW'(ARM_CYC)), .cnt(arm_cnt), .nz(arm_nz));

  eep_countdown #(.W(BW)) u_busy (
    .clk(clk), .rst_n(rst_n), .load(prog_go),
    .load_val(dur), .cnt(busy_cnt), .nz(busy_nz));

  eep_countdown #(.W(SW)) u_stall (
    .clk(clk), .rst_n(rst_n), .load(rd_req || prog_go),
    .load_val(stall_val), .cnt(stall_cnt), .nz(stall_nz));

  eep_cell_array #(.ADDR_W(ADDR_W)) u_cells (
    .clk(clk), .rst_n(rst_n), .addr(cell_addr), .upd_en(prog_go),
    .do_erase(do_erase), .do_write(do_write), .wbyte(data_q), .rbyte(cell_rd));

  // next state
  always_comb begin
    ien_d  = ien_q;
    mode_d = mode_q;
    data_d = data_q;
    alo_d  = alo_q;
    ahi_d  = ahi_q;
    rdk_d  = rdk_q;
    if (ctl_wr) begin
      ien_d  = bus_wdata[CB_IEN];
      mode_d = bus_wdata[CB_NOER:CB_NOWR];
    end
    if (rd_req) data_d = cell_rd;
    else if (bus_wr && bus_sel == SEL_DATA) data_d = bus_wdata;
    if (bus_wr && bus_sel == SEL_ALO) alo_d = bus_wdata;
    if (bus_wr && bus_sel == SEL_AHI) ahi_d = bus_wdata;
    if (rd_req)       rdk_d = 1'b1;
    else if (prog_go) rdk_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q  <= 1'b0;
      mode_q <= 2'b00;
      data_q <= 8'h00;
      alo_q  <= 8'h00;
      ahi_q  <= 8'h00;
      rdk_q  <= 1'b0;
    end else begin
      ien_q  <= ien_d;
      mode_q <= mode_d;
      data_q <= data_d;
      alo_q  <= alo_d;
      ahi_q  <= ahi_d;
      rdk_q  <= rdk_d;
    end
  end

  // read mux and outputs
  always_comb begin
    unique case (bus_sel)
      SEL_CTL:  bus_rdata = {2'b00, mode_q, ien_q, arm_nz, busy_nz, 1'b0};
      SEL_DATA: bus_rdata = data_q;
      SEL_ALO:  bus_rdata = alo_q;
      default:  bus_rdata = ahi_q;
    endcase
  end

  assign cpu_stall = stall_nz;
  assign irq       = ien_q && !busy_nz && !(stall_nz && rdk_q);

  AST_IRQ_QUIET_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_nz |-> !irq); // R10
  AST_START_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_nz) |-> $past(arm_nz || (ctl_wr && bus_wdata[CB_ARM]))); // R3
  AST_BUSY_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_nz && ctl_wr) |=> (busy_cnt == $past(busy_cnt) - 1'b1)); // R5
  AST_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> (cpu_stall && !irq && !$rose(busy_nz))); // R8
  AST_ARM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    arm_cnt <= AW'(ARM_CYC)); // R3
endmodule

// File: tb/sim_eep_ctrl.sv
module sim_eep_ctrl;
  localparam int CLK_PER = 10;
  localparam int AWD = 9;
  localparam int ER  = 40;
  localparam int WR  = 25;
  localparam int ARM = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_sel = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       cpu_stall, irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // behavioural reference state
  bit [7:0] m_mem [1 << AWD];
  bit [7:0] m_data, m_alo, m_ahi;
  bit [1:0] m_mode;
  bit       m_ien, m_srd;
  int       m_arm, m_busy, m_stall;

  always #(CLK_PER/2) clk = ~clk;

  eep_ctrl #(.ADDR_W(AWD), .ERASE_CYC(ER), .WRITE_CYC(WR), .ARM_CYC(ARM),
             .RD_STALL(4), .PG_STALL(2)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_stall(cpu_stall), .irq(irq));

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int m_addr();
    return int'({m_ahi, m_alo}) & ((1 << AWD) - 1);
  endfunction

  task automatic model_reset();
    for (int i = 0; i < (1 << AWD); i++) m_mem[i] = 8'hFF;
    m_data = 0; m_alo = 0; m_ahi = 0; m_mode = 0; m_ien = 0; m_srd = 0;
    m_arm = 0; m_busy = 0; m_stall = 0;
  endtask

  task automatic model_edge(input bit wr, input bit [1:0] sel, input bit [7:0] wd);
    bit ctlw, armed, busy_pre;
    bit [7:0] c;
    int a;
    ctlw = wr && sel == 2'd0;
    armed = (m_arm != 0) || (ctlw && wd[2]);
    busy_pre = m_busy != 0;
    a = m_addr();
    if (m_arm > 0) m_arm--;
    if (m_busy > 0) m_busy--;
    if (m_stall > 0) m_stall--;
    if (ctlw) begin
      m_ien = wd[3];
      m_mode = wd[5:4];
      if (wd[2]) m_arm = ARM;
      if (wd[0]) begin
        m_data = m_mem[a]; m_stall = 4; m_srd = 1;
      end else if (wd[1] && armed && !busy_pre) begin
        c = m_mem[a];
        if (!wd[5]) c = 8'hFF;
        if (!wd[4]) c = c & m_data;
        m_mem[a] = c;
        m_busy = (wd[5] ? 0 : ER) + (wd[4] ? 0 : WR);
        m_stall = 2; m_srd = 0;
      end
    end
    if (wr && sel == 2'd1) m_data = wd;
    if (wr && sel == 2'd2) m_alo = wd;
    if (wr && sel == 2'd3) m_ahi = wd;
  endtask

  task automatic compare_all();
    bit [7:0] exp_rd;
    string rq;
    case (bus_sel)
      2'd0: begin exp_rd = {2'b00, m_mode, m_ien, m_arm != 0, m_busy != 0, 1'b0}; rq = "R2"; end
      2'd1: begin exp_rd = m_data; rq = "R8"; end
      2'd2: begin exp_rd = m_alo; rq = "R11"; end
      default: begin exp_rd = m_ahi; rq = "R11"; end
    endcase
    check(bus_rdata == exp_rd, rq, "rdata", bus_rdata, exp_rd);
    check(cpu_stall == (m_stall != 0), "R9", "cpu_stall", cpu_stall, m_stall != 0);
    check(irq == (m_ien && m_busy == 0 && !(m_stall != 0 && m_srd)), "R10", "irq",
          irq, m_ien && m_busy == 0 && !(m_stall != 0 && m_srd));
  endtask

  // one clock: drive after negedge, model at posedge, compare at next negedge
  task automatic step(input bit wr, input bit [1:0] sel, input bit [7:0] wd);
    bus_wr = wr; bus_sel = sel; bus_wdata = wd;
    @(posedge clk);
    model_edge(wr, sel, wd);
    @(negedge clk);
    compare_all();
    bus_wr = 1'b0;
  endtask

  task automatic idle(input int n, input bit [1:0] sel);
    for (int i = 0; i < n; i++) step(1'b0, sel, 8'h00);
  endtask

  task automatic set_addr(input int a);
    step(1'b1, 2'd2, a[7:0]);
    step(1'b1, 2'd3, a[15:8]);
  endtask

  task automatic expect_cell(input int a, input bit [7:0] v, input string req);
    set_addr(a);
    step(1'b1, 2'd0, 8'h01);
    idle(4, 2'd1);
    check(bus_rdata == v, req, "cell value", bus_rdata, v);
  endtask

  initial begin
    model_reset();
    bus_wr = 0; bus_sel = 0; bus_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values on every register and outputs
    for (int s = 0; s < 4; s++) begin
      bus_sel = 2'(s);
      #1;
      check(bus_rdata == 8'h00, "R1", "reg after reset", bus_rdata, 0);
    end
    check(cpu_stall == 1'b0 && irq == 1'b0, "R1", "outputs after reset", {cpu_stall, irq}, 0);
    @(negedge clk);
    expect_cell(9'h123, 8'hFF, "R1");

    // R2: read strobe bit not stored, address is {hi,lo}
    step(1'b1, 2'd0, 8'h39);
    check(bus_rdata[0] == 1'b0, "R2", "read strobe stored", bus_rdata[0], 0);
    idle(4, 2'd0);

    // R6/R9: write-only AND into erased cell
    set_addr(9'h123);
    step(1'b1, 2'd1, 8'h5A);
    step(1'b1, 2'd0, 8'h0C);
    step(1'b1, 2'd0, 8'h2A);
    check(bus_rdata[1] == 1'b1 && cpu_stall == 1'b1, "R9", "program start", {bus_rdata[1], cpu_stall}, 3);
    idle(WR + 2, 2'd0);
    expect_cell(9'h123, 8'h5A, "R6");
    // R6: second write ANDs on top
    step(1'b1, 2'd1, 8'hF0);
    step(1'b1, 2'd0, 8'h0C);
    step(1'b1, 2'd0, 8'h2A);
    idle(WR + 2, 2'd0);
    expect_cell(9'h123, 8'h50, "R6");
    // R7: erase-only
    step(1'b1, 2'd0, 8'h0C);
    step(1'b1, 2'd0, 8'h1A);
    idle(ER - 1, 2'd0);
    check(bus_rdata[1] == 1'b1, "R7", "busy last erase cycle", bus_rdata[1], 1);
    idle(1, 2'd0);
    check(bus_rdata[1] == 1'b0, "R7", "busy after erase", bus_rdata[1], 0);
    expect_cell(9'h123, 8'hFF, "R6");

    // R7 combined erase+write, R5 ignore while busy, R11 writes while busy
    step(1'b1, 2'd1, 8'h5A);
    step(1'b1, 2'd0, 8'h0C);
    step(1'b1, 2'd0, 8'h2A);
    idle(WR + 2, 2'd0);
    step(1'b1, 2'd1, 8'h0F);
    step(1'b1, 2'd0, 8'h0C);
    step(1'b1, 2'd0, 8'h0A);
    idle(5, 2'd0);
    step(1'b1, 2'd0, 8'h0C);
    step(1'b1, 2'd0, 8'h1A);     // R5: ignored request
    step(1'b1, 2'd1, 8'h33);     // R11
    check(bus_rdata == 8'h33, "R11", "data write while busy", bus_rdata, 8'h33);
    idle(ER + WR - 10, 2'd0);
    check(bus_rdata[1] == 1'b1, "R5", "busy not cut short", bus_rdata[1], 1);
    idle(4, 2'd0);
    check(bus_rdata[1] == 1'b0, "R7", "combined duration end", bus_rdata[1], 0);
    expect_cell(9'h123, 8'h0F, "R5");

    // R4: program after window expired
    step(1'b1, 2'd1, 8'h00);
    step(1'b1, 2'd0, 8'h0C);
    idle(ARM, 2'd0);
    step(1'b1, 2'd0, 8'h0A);
    check(bus_rdata[1] == 1'b0 && cpu_stall == 1'b0, "R4", "unarmed program", {bus_rdata[1], cpu_stall}, 0);
    idle(2, 2'd0);
    expect_cell(9'h123, 8'h0F, "R4");

    // R3: request on the last window cycle starts
    step(1'b1, 2'd0, 8'h0C);
    check(bus_rdata[2] == 1'b1, "R3", "arm readback", bus_rdata[2], 1);
    idle(ARM - 1, 2'd0);
    step(1'b1, 2'd0, 8'h1A);
    check(bus_rdata[1] == 1'b1, "R3", "last window cycle", bus_rdata[1], 1);
    idle(ER + 2, 2'd0);
    // R3: arm and program in one write
    step(1'b1, 2'd1, 8'hC3);
    step(1'b1, 2'd0, 8'h2E);
    check(bus_rdata[1] == 1'b1, "R3", "same-write arm", bus_rdata[1], 1);
    idle(WR + 2, 2'd0);
    expect_cell(9'h123, 8'hC3, "R3");

    // R8: read and program in the same write, read wins
    set_addr(9'h1F0);
    step(1'b1, 2'd0, 8'h2F);
    check(bus_rdata[1] == 1'b0 && cpu_stall == 1'b1 && irq == 1'b0, "R8",
          "read beats program", {bus_rdata[1], cpu_stall, irq}, 3'b010);
    idle(3, 2'd1);
    check(cpu_stall == 1'b1, "R8", "read stall 4th cycle", cpu_stall, 1);
    idle(1, 2'd1);
    check(cpu_stall == 1'b0 && irq == 1'b1, "R10", "irq after read stall", {cpu_stall, irq}, 1);
    expect_cell(9'h1F0, 8'hFF, "R8");

    // R7: mode 11 changes nothing, only stalls
    set_addr(9'h123);
    step(1'b1, 2'd0, 8'h0C);
    step(1'b1, 2'd0, 8'h3A);
    check(bus_rdata[1] == 1'b0 && cpu_stall == 1'b1, "R7", "no-op mode", {bus_rdata[1], cpu_stall}, 1);
    idle(3, 2'd0);
    expect_cell(9'h123, 8'hC3, "R7");
    done = 1'b1;
  end

  initial begin : watchdog
    for (int i = 0; i < 200000 && !done; i++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule